// File: doc/BRIEF.md
# Address Translation Cache with Ranged Invalidation

This block is a small, fully associative cache of address translations. Each entry is keyed by an address-space identifier (ASID), a page-aligned input address, a granule code and a table level. Each entry also carries a page mask and a stored output address. A fill port writes new translations. A combinational lookup port reports hit or miss and returns the translated address, with the in-page offset taken from the lookup address.

A command port accepts stage-1 invalidate-by-address commands as four 32-bit words under a valid/ready handshake. The block decodes the granule, count and scale fields into a byte span and clears every cached translation that overlaps that span. When the level hint is set and exactly one page is named, it instead clears only the entry whose full key matches. The cleanup finishes in a single scan cycle, which is flagged by a one-cycle done pulse.

Top module: `xlat_cache_rinv`

## Requirements
- R1: After reset no entry is valid, every lookup misses, `cmd_ready` is 1 and `cmd_done` is 0.
- R2: A lookup hits when a valid entry has an equal ASID and `(lu_va & ~mask) == stored_va`. The result is `(stored_pa & ~mask) | (lu_va & mask)`. When several entries hit, the lowest index wins.
- R3: A fill writes the lowest-index invalid entry. When all entries are valid, it overwrites the entry chosen by a victim counter. The counter starts at 0 after reset, advances by one on each such overwrite, and wraps at the entry count.
- R4: When a command is accepted (`cmd_valid && cmd_ready`), `cmd_done` is 1 in the next cycle only. `cmd_ready` is 0 in exactly that cycle.
- R5: Type byte `w0[7:0]` = 0x12 invalidates for the ASID in `w1[31:16]`. Type 0x13 matches every ASID. Any other type is consumed and changes nothing. The address is `{w3, w2[31:12], 12'h000}`.
- R6: When the granule code `w2[11:10]` is 0, the command names one 4 KB page (range mask 0xFFF), and the count, scale and level fields are ignored.
- R7: When the granule code G is nonzero, the granule is `2^(2G+10)` bytes. The page count is `(w0[16:12]+1) << w0[24:20]`. The range mask is `(pages << log2 granule) - 1`.
- R8: In range mode, an entry is cleared when its ASID qualifies and either `(addr & ~entry_mask) == entry_va` or `(entry_va & ~range_mask) == addr` holds.
- R9: When the level hint `w2[9:8]` is nonzero and the page count is 1, only entries with `entry_va == addr`, equal granule code and `entry_level == hint` are cleared (ASID rules as in R5).
- R10: Lookups made during the done cycle see the contents from before the invalidation. Cleared entries miss from the following cycle on.
- R11: A fill made during the done cycle is applied after the clearing, so it survives even if it lies inside the range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_en | input | 1 | Write one translation this cycle |
| fill_asid | input | 16 | ASID of the new entry |
| fill_va | input | 64 | Input address of the new entry |
| fill_mask | input | 64 | Page offset mask of the new entry |
| fill_tg | input | 2 | Granule code of the new entry |
| fill_lvl | input | 2 | Table level of the new entry |
| fill_pa | input | 64 | Output address of the new entry |
| lu_asid | input | 16 | Lookup ASID |
| lu_va | input | 64 | Lookup input address |
| lu_hit | output | 1 | Lookup found a translation |
| lu_pa | output | 64 | Translated address |
| cmd_valid | input | 1 | Command words are present |
| cmd_ready | output | 1 | Command is taken this cycle |
| cmd_w0 | input | 32 | Command word 0 (type, count, scale) |
| cmd_w1 | input | 32 | Command word 1 (ASID) |
| cmd_w2 | input | 32 | Command word 2 (low address, granule, level) |
| cmd_w3 | input | 32 | Command word 3 (high address) |
| cmd_done | output | 1 | Invalidation scan cycle |

## Verification
The bench checks that a zero granule code really discards stale count, scale and level bits. A design that honoured them would wipe neighbouring pages. It checks an address inside a large page that is not aligned to that page, which only the entry-mask comparison catches; a design that kept only one of the two overlap tests would leave that translation alive. Exact-key mode is exercised with a same-address entry at another level and with a granule mismatch, either of which an over-eager design would drop. The bench also places a lookup and a fill inside the scan cycle and overflows the cache: the first exposes early clearing, the second exposes clearing after the fill, and the overflow exposes a wrong victim order.

// File: rtl/xcr_pkg.sv
package xcr_pkg;
    localparam int ADDR_W = 64;
    localparam int ASID_W = 16;
    localparam int WORD_W = 32;
    localparam logic [7:0] OP_INV_ONE_AS = 8'h12;
    localparam logic [7:0] OP_INV_ALL_AS = 8'h13;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic [ADDR_W-1:0] va;
        logic [ADDR_W-1:0] mask;
        logic [1:0]        tg;
        logic [1:0]        lvl;
        logic [ADDR_W-1:0] pa;
    } tlb_ent_t;

    typedef struct packed {
        logic              act;
        logic              wild;
        logic              exact;
        logic [ASID_W-1:0] asid;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        tg;
        logic [1:0]        ttl;
        logic [ADDR_W-1:0] rmask;
    } inv_req_t;
endpackage

// File: rtl/xcr_span_mask.sv
module xcr_span_mask #(
    parameter int AW = 64
) (
    input  logic [4:0]    num,
    input  logic [4:0]    scale,
    input  logic [4:0]    glog,
    output logic [AW-1:0] mask
);
    localparam int WIDE_W = AW + 64;

    logic [WIDE_W-1:0] span;
    logic [5:0]        sh;
    logic              sat;

    always_comb begin
        sh   = {1'b0, scale} + {1'b0, glog};
        span = (WIDE_W'(num) + WIDE_W'(1)) << sh;
        sat  = |span[WIDE_W-1:AW];
        mask = sat ? '1 : (span[AW-1:0] - AW'(1));
    end
endmodule

// File: rtl/xcr_cmd_decode.sv
module xcr_cmd_decode
    import xcr_pkg::*;
(
    input  logic [WORD_W-1:0] w0,
    input  logic [WORD_W-1:0] w1,
    input  logic [WORD_W-1:0] w2,
    input  logic [WORD_W-1:0] w3,
    output inv_req_t          req
);
    logic [7:0]        op;
    logic [1:0]        tg;
    logic [4:0]        num_d;
    logic [4:0]        scale_d;
    logic [4:0]        glog_d;
    logic [1:0]        ttl_d;
    logic [ADDR_W-1:0] rmask;
    logic              unused_ok;

    assign unused_ok = ^{w0[31:25], w0[19:17], w0[11:8], w1[15:0], w2[7:0]};

    always_comb begin
        op      = w0[7:0];
        tg      = w2[11:10];
        num_d   = (tg != 2'd0) ? w0[16:12] : 5'd0;
        scale_d = (tg != 2'd0) ? w0[24:20] : 5'd0;
        ttl_d   = (tg != 2'd0) ? w2[9:8]   : 2'd0;
        glog_d  = (tg != 2'd0) ? (5'd10 + {2'b0, tg, 1'b0}) : 5'd12;
    end

    xcr_span_mask #(.AW(ADDR_W)) u_span (
        .num   (num_d),
        .scale (scale_d),
        .glog  (glog_d),
        .mask  (rmask)
    );

    always_comb begin
        req       = '0;
        req.act   = (op == OP_INV_ONE_AS) || (op == OP_INV_ALL_AS);
        req.wild  = (op == OP_INV_ALL_AS);
        req.asid  = w1[31:16];
        req.addr  = {w3, w2[31:12], 12'h000};
        req.tg    = tg;
        req.ttl   = ttl_d;
        req.exact = (ttl_d != 2'd0) && (num_d == 5'd0) && (scale_d == 5'd0);
        req.rmask = rmask;
    end
endmodule

// File: rtl/xcr_kill_scan.sv
module xcr_kill_scan
    import xcr_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]     valid,
    input  tlb_ent_t [N-1:0] ents,
    input  inv_req_t         req,
    output logic [N-1:0]     kill
);
    for (genvar g = 0; g < N; g++) begin : g_ent
        logic asid_ok, near_hit, span_hit, key_hit;
        assign asid_ok  = req.wild || (ents[g].asid == req.asid);
        assign near_hit = (req.addr & ~ents[g].mask) == ents[g].va;
        assign span_hit = (ents[g].va & ~req.rmask) == req.addr;
        assign key_hit  = (ents[g].va == req.addr) && (ents[g].tg == req.tg)
                       && (ents[g].lvl == req.ttl);
        assign kill[g]  = valid[g] && req.act && asid_ok
                       && (req.exact ? key_hit : (near_hit || span_hit));
    end
endmodule

// File: rtl/xcr_probe.sv
module xcr_probe
    import xcr_pkg::*;
#(
    parameter int N = 16
) (
    input  logic [N-1:0]      valid,
    input  tlb_ent_t [N-1:0]  ents,
    input  logic [ASID_W-1:0] asid,
    input  logic [ADDR_W-1:0] va,
    output logic              hit,
    output logic [ADDR_W-1:0] pa
);
    always_comb begin
        hit = 1'b0;
        pa  = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (valid[i] && (ents[i].asid == asid)
                && ((va & ~ents[i].mask) == ents[i].va)) begin
                hit = 1'b1;
                pa  = ents[i].pa | (va & ents[i].mask);
            end
        end
    end
endmodule

// File: rtl/xlat_cache_rinv.sv
module xlat_cache_rinv
    import xcr_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fill_en,
    input  logic [15:0] fill_asid,
    input  logic [63:0] fill_va,
    input  logic [63:0] fill_mask,
    input  logic [1:0]  fill_tg,
    input  logic [1:0]  fill_lvl,
    input  logic [63:0] fill_pa,
    input  logic [15:0] lu_asid,
    input  logic [63:0] lu_va,
    output logic        lu_hit,
    output logic [63:0] lu_pa,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [31:0] cmd_w0,
    input  logic [31:0] cmd_w1,
    input  logic [31:0] cmd_w2,
    input  logic [31:0] cmd_w3,
    output logic        cmd_done
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]     valid;
        tlb_ent_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]       rr;
        logic                   busy;
        inv_req_t               req;
    } st_t;

    st_t                q, d;
    inv_req_t           dec;
    logic [ENTRIES-1:0] kill;

    xcr_cmd_decode u_dec (
        .w0  (cmd_w0),
        .w1  (cmd_w1),
        .w2  (cmd_w2),
        .w3  (cmd_w3),
        .req (dec)
    );

    xcr_kill_scan #(.N(ENTRIES)) u_kill (
        .valid (q.valid),
        .ents  (q.ent),
        .req   (q.req),
        .kill  (kill)
    );

    xcr_probe #(.N(ENTRIES)) u_probe (
        .valid (q.valid),
        .ents  (q.ent),
        .asid  (lu_asid),
        .va    (lu_va),
        .hit   (lu_hit),
        .pa    (lu_pa)
    );

    always_comb begin
        logic             found;
        logic [IDX_W-1:0] slot;
        d = q;
        if (q.busy) begin
            d.valid = q.valid & ~kill;
        end
        found = 1'b0;
        slot  = q.rr;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!d.valid[i]) begin
                found = 1'b1;
                slot  = IDX_W'(i);
            end
        end
        if (fill_en) begin
            d.valid[slot]    = 1'b1;
            d.ent[slot].asid = fill_asid;
            d.ent[slot].va   = fill_va & ~fill_mask;
            d.ent[slot].mask = fill_mask;
            d.ent[slot].tg   = fill_tg;
            d.ent[slot].lvl  = fill_lvl;
            d.ent[slot].pa   = fill_pa & ~fill_mask;
            if (!found) begin
                d.rr = (q.rr == IDX_W'(ENTRIES - 1)) ? '0 : q.rr + 1'b1;
            end
        end
        d.busy = cmd_valid && !q.busy;
        if (cmd_valid && !q.busy) begin
            d.req = dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cmd_ready = !q.busy;
    assign cmd_done  = q.busy;

    // R4
    accept_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> cmd_done);
    // R4
    done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !cmd_ready);
    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);
    // R8
    kill_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_done && !fill_en) |=> ((q.valid & $past(kill)) == '0));
    // R2
    hit_needs_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lu_hit |-> (q.valid != '0));
endmodule

// File: tb/xlat_cache_rinv_tb_top.sv
`timescale 1ns/1ps
module xlat_cache_rinv_tb_top;
    localparam int NE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fill_en = 1'b0;
    logic [15:0] fill_asid = '0;
    logic [63:0] fill_va = '0, fill_mask = '0, fill_pa = '0;
    logic [1:0]  fill_tg = '0, fill_lvl = '0;
    logic [15:0] lu_asid = '0;
    logic [63:0] lu_va = '0;
    logic        lu_hit;
    logic [63:0] lu_pa;
    logic        cmd_valid = 1'b0, cmd_ready, cmd_done;
    logic [31:0] cmd_w0 = '0, cmd_w1 = '0, cmd_w2 = '0, cmd_w3 = '0;

    int checks = 0, errors = 0, cycles = 0;
    string cur_tag = "R1";

    bit          m_v[NE];
    logic [15:0] m_as[NE];
    logic [63:0] m_va[NE], m_mk[NE], m_pa[NE];
    logic [1:0]  m_tg[NE], m_lv[NE];
    int          m_rr = 0;
    bit          m_busy = 0;
    logic [31:0] m_w[4];

    always #2.5 clk = ~clk;

    xlat_cache_rinv dut_i (
        .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .fill_asid(fill_asid),
        .fill_va(fill_va), .fill_mask(fill_mask), .fill_tg(fill_tg),
        .fill_lvl(fill_lvl), .fill_pa(fill_pa), .lu_asid(lu_asid), .lu_va(lu_va),
        .lu_hit(lu_hit), .lu_pa(lu_pa), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_w0(cmd_w0), .cmd_w1(cmd_w1), .cmd_w2(cmd_w2), .cmd_w3(cmd_w3),
        .cmd_done(cmd_done));

    task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural clearing per R5..R9
    task automatic m_invalidate();
        logic [7:0]   op;
        logic [1:0]   tg, ttl;
        logic [127:0] pages, span;
        logic [63:0]  rm, ad;
        int           glog;
        bit           any, hitc;
        op = m_w[0][7:0];
        if (op != 8'h12 && op != 8'h13) return;
        tg = m_w[2][11:10];
        if (tg != 0) begin
            pages = 128'(m_w[0][16:12] + 1) << m_w[0][24:20];
            glog  = 2 * tg + 10;
            ttl   = m_w[2][9:8];
        end else begin
            pages = 1; glog = 12; ttl = 0;
        end
        span = pages << glog;
        rm   = (span[127:64] != 0) ? '1 : span[63:0] - 1;
        ad   = {m_w[3], m_w[2][31:12], 12'h000};
        any  = (op == 8'h13);
        for (int i = 0; i < NE; i++) begin
            if (!m_v[i] || !(any || m_as[i] == m_w[1][31:16])) continue;
            if (ttl != 0 && pages == 1)
                hitc = (m_va[i] == ad) && (m_tg[i] == tg) && (m_lv[i] == ttl);
            else
                hitc = ((ad & ~m_mk[i]) == m_va[i]) || ((m_va[i] & ~rm) == ad);
            if (hitc) m_v[i] = 0;
        end
    endtask

    task automatic step();
        bit          eh = 0;
        logic [63:0] ep = '0;
        int          slot;
        #1;
        for (int i = NE - 1; i >= 0; i--)
            if (m_v[i] && m_as[i] == lu_asid && (lu_va & ~m_mk[i]) == m_va[i]) begin
                eh = 1; ep = m_pa[i] | (lu_va & m_mk[i]);
            end
        chk("R4", "cmd_ready", 64'(cmd_ready), 64'(!m_busy));
        chk("R4", "cmd_done", 64'(cmd_done), 64'(m_busy));
        chk(cur_tag, "lu_hit", 64'(lu_hit), 64'(eh));
        if (eh) chk(cur_tag, "lu_pa", lu_pa, ep);
        @(posedge clk);
        if (m_busy) m_invalidate();
        if (fill_en) begin
            slot = -1;
            for (int i = NE - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % NE; end
            m_v[slot] = 1; m_as[slot] = fill_asid; m_mk[slot] = fill_mask;
            m_va[slot] = fill_va & ~fill_mask; m_pa[slot] = fill_pa & ~fill_mask;
            m_tg[slot] = fill_tg; m_lv[slot] = fill_lvl;
        end
        if (cmd_valid && !m_busy) begin
            m_w[0] = cmd_w0; m_w[1] = cmd_w1; m_w[2] = cmd_w2; m_w[3] = cmd_w3;
            m_busy = 1;
        end else m_busy = 0;
        @(negedge clk);
    endtask

    task automatic put(logic [15:0] a, logic [63:0] va, logic [63:0] mk,
                       logic [1:0] tg, logic [1:0] lv, logic [63:0] pa);
        fill_en = 1; fill_asid = a; fill_va = va; fill_mask = mk;
        fill_tg = tg; fill_lvl = lv; fill_pa = pa;
        step();
        fill_en = 0;
    endtask

    task automatic look(string tag, logic [15:0] a, logic [63:0] va);
        cur_tag = tag; lu_asid = a; lu_va = va;
        step();
    endtask

    task automatic inv(logic [7:0] op, logic [15:0] a, logic [63:0] ad, logic [1:0] tg,
                       logic [1:0] ttl, logic [4:0] num, logic [4:0] sc);
        cmd_w0 = (32'(sc) << 20) | (32'(num) << 12) | 32'(op);
        cmd_w1 = 32'(a) << 16;
        cmd_w2 = {ad[31:12], tg, ttl, 8'h00};
        cmd_w3 = ad[63:32];
        cmd_valid = 1;
        step();
        cmd_valid = 0;
        step();
    endtask

    task automatic clear_all();
        inv(8'h13, 16'h0, 64'h0, 2'd3, 2'd0, 5'd31, 5'd31);
    endtask

    initial begin
        for (int i = 0; i < NE; i++) m_v[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1: reset state
        look("R1", 16'h0, 64'h0);
        look("R1", 16'h5, 64'h1000);
        // R2: fill and lookups
        put(16'h5, 64'h1000_0000, 64'hFFF, 2'd1, 2'd3, 64'h8000_0000);
        put(16'h5, 64'h2000_0000, 64'h1F_FFFF, 2'd1, 2'd2, 64'h9000_0000);
        put(16'h5, 64'h1000_0000, 64'hFFF, 2'd1, 2'd3, 64'hA000_0000);
        look("R2", 16'h5, 64'h1000_0ABC);
        look("R2", 16'h6, 64'h1000_0ABC);
        look("R2", 16'h5, 64'h2012_3456);
        look("R2", 16'h5, 64'h2020_0000);
        clear_all();
        look("R5", 16'h5, 64'h1000_0000);
        // R6: zero granule ignores count/scale/level
        put(16'h5, 64'h10000, 64'hFFF, 2'd1, 2'd3, 64'h1_0000);
        put(16'h5, 64'h11000, 64'hFFF, 2'd1, 2'd3, 64'h1_1000);
        put(16'h6, 64'h10000, 64'hFFF, 2'd1, 2'd3, 64'h1_2000);
        cmd_w0 = 0;
        inv(8'h12, 16'h5, 64'h10000, 2'd0, 2'd3, 5'd5, 5'd2);
        look("R6", 16'h5, 64'h10000);
        look("R6", 16'h5, 64'h11000);
        look("R6", 16'h6, 64'h10000);
        clear_all();
        // R7: ranges for 4K and 16K granules
        put(16'h5, 64'h20000, 64'hFFF, 2'd1, 2'd3, 64'h3_0000);
        put(16'h5, 64'h27000, 64'hFFF, 2'd1, 2'd3, 64'h3_7000);
        put(16'h5, 64'h28000, 64'hFFF, 2'd1, 2'd3, 64'h3_8000);
        inv(8'h12, 16'h5, 64'h20000, 2'd1, 2'd0, 5'd3, 5'd1);
        look("R7", 16'h5, 64'h20000);
        look("R7", 16'h5, 64'h27000);
        look("R7", 16'h5, 64'h28000);
        put(16'h5, 64'h40000, 64'h3FFF, 2'd2, 2'd3, 64'h5_0000);
        put(16'h5, 64'h44000, 64'h3FFF, 2'd2, 2'd3, 64'h5_4000);
        put(16'h5, 64'h48000, 64'h3FFF, 2'd2, 2'd3, 64'h5_8000);
        inv(8'h12, 16'h5, 64'h40000, 2'd2, 2'd0, 5'd1, 5'd0);
        look("R7", 16'h5, 64'h40010);
        look("R7", 16'h5, 64'h44010);
        look("R7", 16'h5, 64'h48010);
        clear_all();
        // R8: command address inside a large page
        put(16'h5, 64'h4000_0000, 64'h1F_FFFF, 2'd1, 2'd2, 64'h6000_0000);
        inv(8'h12, 16'h5, 64'h4020_0000, 2'd0, 2'd0, 5'd0, 5'd0);
        look("R8", 16'h5, 64'h4000_0040);
        inv(8'h12, 16'h5, 64'h4012_3000, 2'd0, 2'd0, 5'd0, 5'd0);
        look("R8", 16'h5, 64'h4000_0040);
        // R5: ASID selection and unknown type
        put(16'h1, 64'h5000, 64'hFFF, 2'd1, 2'd3, 64'h7_1000);
        put(16'h2, 64'h5000, 64'hFFF, 2'd1, 2'd3, 64'h7_2000);
        inv(8'h12, 16'h3, 64'h5000, 2'd0, 2'd0, 5'd0, 5'd0);
        look("R5", 16'h1, 64'h5000);
        inv(8'h20, 16'h1, 64'h5000, 2'd0, 2'd0, 5'd0, 5'd0);
        look("R5", 16'h1, 64'h5000);
        look("R5", 16'h2, 64'h5000);
        inv(8'h13, 16'h7, 64'h5000, 2'd0, 2'd0, 5'd0, 5'd0);
        look("R5", 16'h1, 64'h5000);
        look("R5", 16'h2, 64'h5000);
        // R9: exact key removal
        put(16'h5, 64'h6000, 64'hFFF, 2'd1, 2'd2, 64'h8_2000);
        put(16'h5, 64'h6000, 64'hFFF, 2'd1, 2'd3, 64'h8_3000);
        put(16'h5, 64'h7000, 64'hFFF, 2'd1, 2'd2, 64'h8_4000);
        inv(8'h12, 16'h5, 64'h6000, 2'd2, 2'd3, 5'd0, 5'd0);
        look("R9", 16'h5, 64'h6000);
        inv(8'h12, 16'h5, 64'h6000, 2'd1, 2'd2, 5'd0, 5'd0);
        look("R9", 16'h5, 64'h6000);
        look("R9", 16'h5, 64'h7000);
        clear_all();
        // R10: lookup during scan cycle sees old contents
        put(16'h5, 64'h9000, 64'hFFF, 2'd1, 2'd3, 64'h9_9000);
        cur_tag = "R10"; lu_asid = 16'h5; lu_va = 64'h9000;
        inv(8'h12, 16'h5, 64'h9000, 2'd0, 2'd0, 5'd0, 5'd0);
        look("R10", 16'h5, 64'h9000);
        // R11: fill during scan cycle survives
        cmd_w0 = 32'h12; cmd_w1 = 32'h5 << 16; cmd_w2 = 32'hA000; cmd_w3 = 0;
        cmd_valid = 1;
        step();
        cmd_valid = 0;
        fill_en = 1; fill_asid = 16'h5; fill_va = 64'hA000; fill_mask = 64'hFFF;
        fill_tg = 2'd1; fill_lvl = 2'd3; fill_pa = 64'hB_A000;
        step();
        fill_en = 0;
        look("R11", 16'h5, 64'hA000);
        clear_all();
        // R3: overflow replacement order
        for (int i = 1; i <= NE; i++)
            put(16'h5, 64'(i) << 12, 64'hFFF, 2'd1, 2'd3, 64'h100_0000 + (64'(i) << 12));
        put(16'h5, 64'h10_0000, 64'hFFF, 2'd1, 2'd3, 64'h200_0000);
        put(16'h5, 64'h10_1000, 64'hFFF, 2'd1, 2'd3, 64'h201_0000);
        look("R3", 16'h5, 64'h1000);
        look("R3", 16'h5, 64'h2000);
        look("R3", 16'h5, 64'h3000);
        look("R3", 16'h5, 64'h10_0000);
        look("R3", 16'h5, 64'h10_1000);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule